// File: doc/BRIEF.md
# Infrared Carrier Modulator

This block produces the carrier square wave that an infrared transmitter gates with its marks. A two-phase counter alternates between a high phase and a low phase. Each phase length comes from a count register, which stores each length minus one. The counter advances only on ticks from a tick source chosen in the control register. The tick source can be the system clock, a pulse stream from a crystal divided by three, or a 1 µs or 10 µs tick. The 1 µs and 10 µs ticks come from prescalers of the system clock. The carrier frequency is the tick rate divided by the sum of the two phase lengths. The duty cycle is the share of that sum taken by the high phase.

Software writes the block through a simple register write port with two addresses. The recommended bring-up order is as follows. Write the control register with the tick select and the initial-high bit set and the enable bit clear. Program the counts. Clear the initial-high bit. Finally, set the enable bit. While the block is disabled, the counter is parked at the start of the high phase and the output rests at the level chosen by the initial-high bit. A downstream mark sequencer uses two outputs. The first is a gated copy of the carrier, ANDed with its mark input. The second is a one-cycle strobe at each period boundary, which the sequencer can use as a timebase. A new count written while the block is running is held in staging registers and applied only when a period completes, so no phase is cut short.

Top module: `ir_carrier_mod`

## Requirements
- R1: After reset, carrier_o, gated_o and period_o are all low, and the block is disabled with both staged phase fields equal to zero.
- R2: A write with wr_addr_i = 0 loads the control register. Bit 0 is the enable, bit 2 is the initial-high level, and bits [13:12] select the tick source. All other bits are ignored. Without a write, the control state does not change.
- R3: While the enable bit is clear, carrier_o equals the initial-high bit and period_o stays low. The counter is parked, so after the enable is set the first high phase lasts its full programmed length, beginning in the cycle after the enabling write.
- R4: A write with wr_addr_i = 1 stores the high length minus one in bits [31:16] and the low length minus one in bits [15:0]. While enabled, carrier_o is high for (high field + 1) ticks, then low for (low field + 1) ticks, and this repeats.
- R5: period_o pulses for exactly one cycle in the first cycle of each high phase that follows a low phase. Successive pulses are (high field + low field + 2) ticks apart. There is no pulse in the first high phase after enabling.
- R6: A count write while enabled does not change the period in progress. The new lengths apply from the next period boundary. While disabled, a count write applies at once.
- R7: Tick select code 0 advances the counter on every system clock cycle. Code 1 advances it only on cycles where xtal_tick_i is high. With code 1 and no xtal_tick_i pulses, carrier_o does not change.
- R8: Tick select code 2 advances the counter once every SYS_PER_US system cycles. Code 3 advances it once every SYS_PER_US × US_PER_TEN system cycles.
- R9: gated_o equals carrier_o AND mark_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Register select: 0 control, 1 phase counts |
| wr_data_i | input | 2*CNT_W | Register write data |
| xtal_tick_i | input | 1 | One-cycle pulses from the crystal divided by three, in the system clock domain |
| mark_i | input | 1 | Mark gate from the sequencer |
| carrier_o | output | 1 | Carrier waveform (idle level while disabled) |
| gated_o | output | 1 | Carrier ANDed with mark_i |
| period_o | output | 1 | One-cycle strobe at each carrier period boundary |

## Verification
The two events that can coincide are a count write and the end of a period. The bench writes new lengths during the high phase of a long period. It then measures that this period keeps its old high and low lengths to the cycle, and that the next period has the new ones. Disable and re-enable land at arbitrary points in a period. These are judged by checking that the restart always begins with a full-length high phase and with no boundary strobe in the first high phase.

// File: rtl/ircm_pkg.sv
package ircm_pkg;

    typedef enum logic [1:0] {
        TICK_SYS   = 2'd0,
        TICK_XTAL3 = 2'd1,
        TICK_1US   = 2'd2,
        TICK_10US  = 2'd3
    } tick_sel_e;

    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } phase_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_INIT_BIT = 2;
    localparam int CTRL_SEL_LSB  = 12;

    localparam logic ADDR_CTRL  = 1'b0;
    localparam logic ADDR_COUNT = 1'b1;

endpackage

// File: rtl/ircm_regs.sv
module ircm_regs
    import ircm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic                 wr_addr_i,
    input  logic [2*CNT_W-1:0]   wr_data_i,
    output logic                 enable_o,
    output logic                 init_high_o,
    output tick_sel_e            tick_sel_o,
    output logic [CNT_W-1:0]     hi_m1_o,
    output logic [CNT_W-1:0]     lo_m1_o
);

    localparam int DATA_W = 2 * CNT_W;

    typedef struct packed {
        logic             en;
        logic             init_high;
        tick_sel_e        sel;
        logic [CNT_W-1:0] hi_m1;
        logic [CNT_W-1:0] lo_m1;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            if (wr_addr_i == ADDR_COUNT) begin
                st_d.hi_m1 = wr_data_i[DATA_W-1:CNT_W];
                st_d.lo_m1 = wr_data_i[CNT_W-1:0];
            end else begin
                st_d.en        = wr_data_i[CTRL_EN_BIT];
                st_d.init_high = wr_data_i[CTRL_INIT_BIT];
                st_d.sel       = tick_sel_e'(wr_data_i[CTRL_SEL_LSB +: 2]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{en: 1'b0, init_high: 1'b0, sel: TICK_SYS,
                      hi_m1: '0, lo_m1: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign enable_o    = st_q.en;
    assign init_high_o = st_q.init_high;
    assign tick_sel_o  = st_q.sel;
    assign hi_m1_o     = st_q.hi_m1;
    assign lo_m1_o     = st_q.lo_m1;

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ($stable(st_q.en) && $stable(st_q.init_high) && $stable(st_q.sel))); // R2

    AST_COUNT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == ADDR_CTRL) |=> ($stable(st_q.hi_m1) && $stable(st_q.lo_m1))); // R4

endmodule

// File: rtl/ircm_tick_gen.sv
module ircm_tick_gen
    import ircm_pkg::*;
#(
    parameter int SYS_PER_US = 250,
    parameter int US_PER_TEN = 10
) (
    input  logic      clk,
    input  logic      rst_n,
    input  tick_sel_e sel_i,
    input  logic      xtal_tick_i,
    output logic      tick_o
);

    localparam int US_W  = (SYS_PER_US > 1) ? $clog2(SYS_PER_US) : 1;
    localparam int TEN_W = (US_PER_TEN > 1) ? $clog2(US_PER_TEN) : 1;

    logic us_tick;
    logic ten_tick;

    generate
        if (SYS_PER_US > 1) begin : g_us_div
            logic [US_W-1:0] us_cnt_d, us_cnt_q;

            always_comb begin
                us_cnt_d = us_cnt_q + US_W'(1);
                if (us_cnt_q == US_W'(SYS_PER_US - 1)) begin
                    us_cnt_d = '0;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    us_cnt_q <= '0;
                end else begin
                    us_cnt_q <= us_cnt_d;
                end
            end

            assign us_tick = (us_cnt_q == US_W'(SYS_PER_US - 1));

            AST_US_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
                us_cnt_q <= US_W'(SYS_PER_US - 1)); // R8

            AST_US_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                us_tick |=> !us_tick); // R8
        end else begin : g_us_pass
            assign us_tick = 1'b1;
        end
    endgenerate

    logic [TEN_W-1:0] ten_cnt_d, ten_cnt_q;

    always_comb begin
        ten_cnt_d = ten_cnt_q;
        if (us_tick) begin
            if (ten_cnt_q == TEN_W'(US_PER_TEN - 1)) begin
                ten_cnt_d = '0;
            end else begin
                ten_cnt_d = ten_cnt_q + TEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ten_cnt_q <= '0;
        end else begin
            ten_cnt_q <= ten_cnt_d;
        end
    end

    assign ten_tick = us_tick && (ten_cnt_q == TEN_W'(US_PER_TEN - 1));

    always_comb begin
        case (sel_i)
            TICK_SYS:   tick_o = 1'b1;
            TICK_XTAL3: tick_o = xtal_tick_i;
            TICK_1US:   tick_o = us_tick;
            default:    tick_o = ten_tick;
        endcase
    end

    AST_TEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ten_cnt_q <= TEN_W'(US_PER_TEN - 1)); // R8

endmodule

// File: rtl/ircm_phase_ctr.sv
module ircm_phase_ctr
    import ircm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] hi_pend_i,
    input  logic [CNT_W-1:0] lo_pend_i,
    output logic             phase_high_o,
    output logic             strobe_o
);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hi_act;
        logic [CNT_W-1:0] lo_act;
        logic             strobe;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        limit       = (st_q.phase == PH_HIGH) ? st_q.hi_act : st_q.lo_act;
        if (!en_i) begin
            st_d.phase  = PH_HIGH;
            st_d.cnt    = '0;
            st_d.hi_act = hi_pend_i;
            st_d.lo_act = lo_pend_i;
        end else if (tick_i) begin
            if (st_q.cnt == limit) begin
                st_d.cnt = '0;
                if (st_q.phase == PH_HIGH) begin
                    st_d.phase = PH_LOW;
                end else begin
                    st_d.phase  = PH_HIGH;
                    st_d.strobe = 1'b1;
                    st_d.hi_act = hi_pend_i;
                    st_d.lo_act = lo_pend_i;
                end
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_HIGH, cnt: '0, hi_act: '0, lo_act: '0, strobe: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_high_o = (st_q.phase == PH_HIGH);
    assign strobe_o     = st_q.strobe;

    AST_HOLD_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (st_q.phase == PH_HIGH && st_q.cnt == '0)); // R3

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= ((st_q.phase == PH_HIGH) ? st_q.hi_act : st_q.lo_act)); // R4

    AST_STROBE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.strobe |-> (st_q.phase == PH_HIGH && st_q.cnt == '0 && $past(en_i))); // R5

    AST_SWAP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_i) && !st_q.strobe) |-> ($stable(st_q.hi_act) && $stable(st_q.lo_act))); // R6

endmodule

// File: rtl/ir_carrier_mod.sv
module ir_carrier_mod
    import ircm_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int SYS_PER_US = 250,
    parameter int US_PER_TEN = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic                 wr_addr_i,
    input  logic [2*CNT_W-1:0]   wr_data_i,
    input  logic                 xtal_tick_i,
    input  logic                 mark_i,
    output logic                 carrier_o,
    output logic                 gated_o,
    output logic                 period_o
);

    logic             enable;
    logic             init_high;
    tick_sel_e        tick_sel;
    logic [CNT_W-1:0] hi_m1;
    logic [CNT_W-1:0] lo_m1;
    logic             tick;
    logic             phase_high;

    ircm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .enable_o    (enable),
        .init_high_o (init_high),
        .tick_sel_o  (tick_sel),
        .hi_m1_o     (hi_m1),
        .lo_m1_o     (lo_m1)
    );

    ircm_tick_gen #(.SYS_PER_US(SYS_PER_US), .US_PER_TEN(US_PER_TEN)) u_tick (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (tick_sel),
        .xtal_tick_i (xtal_tick_i),
        .tick_o      (tick)
    );

    ircm_phase_ctr #(.CNT_W(CNT_W)) u_phase (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (enable),
        .tick_i       (tick),
        .hi_pend_i    (hi_m1),
        .lo_pend_i    (lo_m1),
        .phase_high_o (phase_high),
        .strobe_o     (period_o)
    );

    always_comb begin
        carrier_o = enable ? phase_high : init_high;
        gated_o   = carrier_o & mark_i;
    end

    AST_OFF_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !$past(enable)) |-> !period_o); // R3

endmodule

// File: tb/ir_carrier_mod_test.sv
module ir_carrier_mod_test;

    localparam int CNT_W = 16;
    localparam int SPU   = 250;
    localparam int UPT   = 10;
    localparam int LIM   = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              wr_addr = 1'b0;
    logic [2*CNT_W-1:0] wr_data = '0;
    logic              xtal_tick = 1'b0;
    logic              mark = 1'b1;
    logic              carrier, gated, period;

    logic xtal_run = 1'b0;
    int   xtal_cnt = 0;
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    always #2 clk = ~clk;

    ir_carrier_mod #(.CNT_W(CNT_W), .SYS_PER_US(SPU), .US_PER_TEN(UPT)) uut (
        .clk (clk), .rst_n (rst_n), .wr_en_i (wr_en), .wr_addr_i (wr_addr),
        .wr_data_i (wr_data), .xtal_tick_i (xtal_tick), .mark_i (mark),
        .carrier_o (carrier), .gated_o (gated), .period_o (period)
    );

    initial begin
        forever begin
            @(negedge clk);
            if (xtal_run) begin
                xtal_cnt  = xtal_cnt + 1;
                xtal_tick = (xtal_cnt % 3 == 0);
            end else begin
                xtal_tick = 1'b0;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic addr, input logic [2*CNT_W-1:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] counts(input int h, input int l);
        return (32'(h) << 16) | 32'(l);
    endfunction

    task automatic measure_runs(output int hi, output int lo);
        int n = 0;
        while (!period && n < LIM) begin @(negedge clk); n++; end
        hi = 0;
        while (carrier && hi < LIM) begin hi++; @(negedge clk); end
        lo = 0;
        while (!carrier && lo < LIM) begin lo++; @(negedge clk); end
    endtask

    // Called at the negedge right after the enabling write took effect.
    task automatic check_wave(input string tag, input int h, input int l, input int nsamp);
        int per = h + l + 2;
        int bad_c = 0, bad_s = 0, bad_g = 0;
        for (int k = 0; k < nsamp; k++) begin
            int p = k % per;
            logic ec = (p <= h);
            logic es = (p == 0) && (k > 0);
            if (carrier !== ec) bad_c++;
            if (period !== es) bad_s++;
            if (gated !== (ec & mark)) bad_g++;
            @(negedge clk);
        end
        check({tag, " R4 carrier mismatches"}, bad_c, 0);
        check({tag, " R5 strobe mismatches"}, bad_s, 0);
        check({tag, " R9 gated mismatches"}, bad_g, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 carrier after reset", int'(carrier), 0);
        check("R1 gated after reset", int'(gated), 0);
        check("R1 strobe after reset", int'(period), 0);
    endtask

    task automatic t_idle_level();
        int hi_seen = 0, st_seen = 0;
        reg_write(1'b0, 32'h0000_0004);
        for (int k = 0; k < 20; k++) begin
            hi_seen += int'(carrier); st_seen += int'(period); @(negedge clk);
        end
        check("R3 idle high level samples", hi_seen, 20);
        check("R3 no strobe while disabled", st_seen, 0);
        reg_write(1'b0, 32'h0000_0000);
        hi_seen = 0;
        for (int k = 0; k < 20; k++) begin hi_seen += int'(carrier); @(negedge clk); end
        check("R3 idle low level samples", hi_seen, 0);
    endtask

    task automatic t_sys_wave();
        // R2 bring-up order: select+init-high, counts, clear init, enable
        reg_write(1'b0, 32'h0000_0004);
        reg_write(1'b1, counts(3, 1));
        reg_write(1'b0, 32'h0000_0000);
        check("R2 init cleared gives low", int'(carrier), 0);
        reg_write(1'b0, 32'h0000_0001);
        check_wave("sys 3/1", 3, 1, 20);
        // disable mid-period, then restart: full high phase first (R3)
        reg_write(1'b0, 32'h0000_0000);
        check("R3 disabled output low", int'(carrier), 0);
        reg_write(1'b1, counts(0, 0));
        reg_write(1'b0, 32'h0000_0001);
        check_wave("R3 restart min 0/0", 0, 0, 10);
        reg_write(1'b0, 32'h0000_0000);
        reg_write(1'b1, counts(0, 4));
        reg_write(1'b0, 32'h0000_0001);
        check_wave("R3 restart 0/4", 0, 4, 15);
        reg_write(1'b0, 32'h0000_0000);
    endtask

    task automatic t_live_update();
        int hi = 0, lo = 0, n = 0;
        reg_write(1'b1, counts(9, 9));
        reg_write(1'b0, 32'h0000_0001);
        while (!period && n < LIM) begin @(negedge clk); n++; end
        while (carrier && hi < LIM) begin
            if (hi == 2) begin wr_en = 1'b1; wr_addr = 1'b1; wr_data = counts(3, 2); end
            else wr_en = 1'b0;
            hi++; @(negedge clk);
        end
        wr_en = 1'b0;
        while (!carrier && lo < LIM) begin lo++; @(negedge clk); end
        check("R6 high of running period", hi, 10);
        check("R6 low of running period", lo, 10);
        check("R6 strobe at boundary", int'(period), 1);
        measure_runs(hi, lo);
        check("R6 new high length", hi, 4);
        check("R6 new low length", lo, 3);
        reg_write(1'b0, 32'h0000_0000);
    endtask

    task automatic t_xtal();
        int hi, lo, changes = 0;
        logic prev;
        reg_write(1'b1, counts(2, 1));
        xtal_run = 1'b1;
        reg_write(1'b0, 32'h0000_1001);
        measure_runs(hi, lo);
        check("R7 xtal tick high run", hi, 9);
        check("R7 xtal tick low run", lo, 6);
        xtal_run = 1'b0;
        @(negedge clk);
        prev = carrier;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (carrier !== prev) changes++;
            prev = carrier;
        end
        check("R7 frozen without xtal ticks", changes, 0);
        reg_write(1'b0, 32'h0000_0000);
    endtask

    task automatic t_slow_ticks();
        int hi, lo;
        reg_write(1'b1, counts(1, 0));
        reg_write(1'b0, 32'h0000_2001);
        measure_runs(hi, lo);
        check("R8 1us high run", hi, 2 * SPU);
        check("R8 1us low run", lo, SPU);
        reg_write(1'b0, 32'h0000_0000);
        reg_write(1'b1, counts(0, 0));
        reg_write(1'b0, 32'h0000_3001);
        measure_runs(hi, lo);
        check("R8 10us high run (R2 select code 3)", hi, SPU * UPT);
        check("R8 10us low run", lo, SPU * UPT);
        reg_write(1'b0, 32'h0000_0000);
    endtask

    task automatic t_gate();
        int g = 0, c = 0;
        reg_write(1'b1, counts(1, 1));
        reg_write(1'b0, 32'h0000_0001);
        mark = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); g += int'(gated); c += int'(carrier);
        end
        check("R9 gated low with mark low", g, 0);
        check("R9 carrier still toggling", int'(c > 0), 1);
        mark = 1'b1;
        reg_write(1'b0, 32'h0000_0000);
        reg_write(1'b0, 32'h0000_0001);
        check_wave("R9 mark high", 1, 1, 12);
        reg_write(1'b0, 32'h0000_0000);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_idle_level();
        t_sys_wave();
        t_live_update();
        t_xtal();
        t_slow_ticks();
        t_gate();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule